// File: doc/BRIEF.md
# Baud-Framed Serial Sample Deserializer

This block sits on the converter side of a synchronous serial link made of three wires: a master clock, a baud strobe and one data line. Every symbol period lasts 48 master-clock cycles and carries 48 data bits. The block samples one bit on each rising clock edge and uses the rising edge of the baud strobe to find where the frame starts. From each frame it takes two 16-bit converter sample words and two 8-bit control bytes.

It presents each sample word on a registered output with a one-cycle valid pulse, so the converter is loaded twice per symbol. A flag tells the first word from the second. The two control bytes go to their own registered outputs, and each one changes at the same moment as the word it travels with. If the strobe re-anchors the frame before it is complete, the block drops the partial frame and raises a one-cycle error pulse.

Top module: `baud_deser`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `smp_word`, `ctrl_a`, `ctrl_b`, `smp_valid`, `smp_second` and `frame_err` are all zero.
- R2: After reset, and until the first rising edge of `baud_in`, the block emits no `smp_valid` and no `frame_err`, whatever arrives on `ser_in`.
- R3: A rising edge of `baud_in` is sampled on a clock edge and sets the frame position to the start. The bit sampled on that same clock is the last bit of the frame before it. Bits 0 to 47 of the new frame arrive on the 48 clocks that follow. The frame order is: sample word A (bits 0 to 15), control byte A (bits 16 to 23), sample word B (bits 24 to 39), control byte B (bits 40 to 47). Each field is sent MSB first.
- R4: One cycle after the clock that samples bit 23, `smp_valid` is 1, `smp_word` holds word A, `smp_second` is 0 and `ctrl_a` holds control byte A.
- R5: One cycle after the clock that samples bit 47, `smp_valid` is 1, `smp_word` holds word B, `smp_second` is 1 and `ctrl_b` holds control byte B.
- R6: A complete frame gives exactly two `smp_valid` pulses, each one cycle long. `smp_word`, `ctrl_a` and `ctrl_b` change only in cycles where `smp_valid` is 1.
- R7: Only a rising edge of `baud_in` counts. A strobe that stays high for several cycles acts the same as a one-cycle strobe, whatever its phase within the frame.
- R8: When no new rising edge arrives, the frame position wraps after bit 47, and the next 48 bits are decoded as the next frame.
- R9: A rising edge of `baud_in` that comes while the frame position is not at bit 47 (after alignment) causes three things. `frame_err` is 1 for exactly one cycle, one cycle after that edge. No `smp_valid` comes from that edge. Capture restarts at bit 0.
- R10: The first rising edge of `baud_in` after reset only aligns the frame and never raises `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all bits are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_in | input | 1 | Baud strobe; its rising edge anchors the frame |
| ser_in | input | 1 | Serial data line |
| smp_word | output | 16 | Most recent converter sample word |
| smp_valid | output | 1 | One-cycle pulse when `smp_word` is refreshed |
| smp_second | output | 1 | 0 for the first word of a frame, 1 for the second |
| ctrl_a | output | 8 | Control byte that travels with word A |
| ctrl_b | output | 8 | Control byte that travels with word B |
| frame_err | output | 1 | One-cycle pulse when a partial frame is dropped |

## Verification
A wrong frame position shows up within one symbol period. A miscounted position makes the valid pulse land at the wrong bit, or decode a word shifted by one or more bits. It also raises `frame_err` on the next strobe edge that is correctly placed. A damaged alignment flag shows as valid pulses before the first strobe, or as a spurious error on the first edge. Both are visible within a few dozen clocks of reset. Wrong field slicing or wrong ordering corrupts the word or control byte at the very next valid pulse.

// File: rtl/baud_deser.sv
module baud_deser #(
  parameter int WORD_W = 16,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_in,
  input  logic              ser_in,
  output logic [WORD_W-1:0] smp_word,
  output logic              smp_valid,
  output logic              smp_second,
  output logic [CTRL_W-1:0] ctrl_a,
  output logic [CTRL_W-1:0] ctrl_b,
  output logic              frame_err
);
  localparam int HALF  = WORD_W + CTRL_W;
  localparam int FRAME = 2 * HALF;
  localparam int CW    = $clog2(FRAME);

  logic            baud_q, synced;
  logic [CW-1:0]   cnt;
  logic [HALF-2:0] sh;

  wire [HALF-1:0] full   = {sh, ser_in};
  wire            rise   = baud_in & ~baud_q;
  wire            mid    = (cnt == CW'(HALF - 1));
  wire            last   = (cnt == CW'(FRAME - 1));
  wire            emit_a = synced & mid & ~rise;
  wire            emit_b = synced & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q     <= 1'b0;
      synced     <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      smp_word   <= '0;
      smp_valid  <= 1'b0;
      smp_second <= 1'b0;
      ctrl_a     <= '0;
      ctrl_b     <= '0;
      frame_err  <= 1'b0;
    end else begin
      baud_q    <= baud_in;
      sh        <= full[HALF-2:0];
      smp_valid <= emit_a | emit_b;
      frame_err <= rise & synced & ~last;
      if (rise) begin
        synced <= 1'b1;
        cnt    <= '0;
      end else if (synced) begin
        cnt <= last ? '0 : cnt + 1'b1;
      end
      if (emit_a) begin
        smp_word   <= full[HALF-1:CTRL_W];
        ctrl_a     <= full[CTRL_W-1:0];
        smp_second <= 1'b0;
      end
      if (emit_b) begin
        smp_word   <= full[HALF-1:CTRL_W];
        ctrl_b     <= full[CTRL_W-1:0];
        smp_second <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_deser_chk.sv
module baud_deser_chk #(
  parameter int WORD_W = 16,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              baud_in,
  input logic [WORD_W-1:0] smp_word,
  input logic              smp_valid,
  input logic [CTRL_W-1:0] ctrl_a,
  input logic [CTRL_W-1:0] ctrl_b,
  input logic              frame_err
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid); // R6
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_word)); // R6
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ($stable(ctrl_a) && $stable(ctrl_b))); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R9
  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !smp_valid); // R9
  AST_ERR_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($past(baud_in) && !$past(baud_in, 2))); // R9
endmodule

bind baud_deser baud_deser_chk #(.WORD_W(WORD_W), .CTRL_W(CTRL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .baud_in(baud_in), .smp_word(smp_word),
  .smp_valid(smp_valid), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .frame_err(frame_err)
);

// File: tb/test_baud_deser.sv
module test_baud_deser;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    48'h1234_5A_ABCD_C3, 48'hFFFF_00_0000_FF, 48'h8001_81_7FFE_7E,
    48'h0000_01_FFFF_80, 48'hA5A5_96_5A5A_69, 48'hDEAD_BE_EF01_23};
  localparam int PW [NV] = '{1, 3, 1, 7, 2, 1};

  logic clk = 0, rst_n = 0, baud_in = 0, ser_in = 0;
  logic [15:0] smp_word;
  logic smp_valid, smp_second, frame_err;
  logic [7:0] ctrl_a, ctrl_b;
  int checks = 0, fails = 0, hi_left = 0;

  always #(CLK_P/2) clk = ~clk;

  baud_deser i_baud_deser (
    .clk(clk), .rst_n(rst_n), .baud_in(baud_in), .ser_in(ser_in),
    .smp_word(smp_word), .smp_valid(smp_valid), .smp_second(smp_second),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .frame_err(frame_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_frame(input logic [47:0] f, input bit end_pulse, input int pw);
    int nval = 0, nerr = 0;
    for (int i = 0; i < 48; i++) begin
      ser_in = f[47-i];
      if (i == 47 && end_pulse) begin baud_in = 1; hi_left = pw - 1; end
      else if (hi_left > 0) begin baud_in = 1; hi_left--; end
      else baud_in = 0;
      @(negedge clk);
      nval += int'(smp_valid);
      nerr += int'(frame_err);
      if (i == 23) begin
        chk(smp_valid && smp_word == f[47:32], "R4", "word A", smp_word, f[47:32]);
        chk(!smp_second && ctrl_a == f[31:24], "R4", "ctrl A", ctrl_a, f[31:24]);
      end
      if (i == 47) begin
        chk(smp_valid && smp_word == f[23:8], "R5", "word B", smp_word, f[23:8]);
        chk(smp_second && ctrl_b == f[7:0], "R5", "ctrl B", ctrl_b, f[7:0]);
      end
    end
    chk(nval == 2, "R6", "valid pulses per frame", nval, 2);
    chk(nerr == 0, "R9", "no error on full frame", nerr, 0);
  endtask

  task automatic send_partial(input logic [47:0] f, input int k, input int exp_val);
    int nval = 0;
    logic [15:0] w;
    for (int i = 0; i < k; i++) begin
      ser_in = f[47-i];
      baud_in = 0;
      @(negedge clk);
      nval += int'(smp_valid);
    end
    chk(nval == exp_val, "R9", "valids before early edge", nval, exp_val);
    w = smp_word;
    ser_in = f[47-k];
    baud_in = 1;
    hi_left = 0;
    @(negedge clk);
    chk(frame_err == 1, "R9", "error pulse on early edge", frame_err, 1);
    chk(smp_valid == 0 && smp_word == w, "R9", "no word from early edge", smp_word, w);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int nv;
    repeat (3) @(negedge clk);
    chk(smp_word == 0 && ctrl_a == 0 && ctrl_b == 0, "R1", "outputs in reset",
        {smp_word, ctrl_a, ctrl_b}, 0);
    chk(!smp_valid && !frame_err && !smp_second, "R1", "flags in reset",
        {smp_valid, frame_err, smp_second}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!smp_valid && !frame_err && smp_word == 0, "R1", "after release", smp_word, 0);
    nv = 0;
    for (int i = 0; i < 60; i++) begin
      ser_in = i[0] ^ i[2];
      @(negedge clk);
      nv += int'(smp_valid) + int'(frame_err);
    end
    chk(nv == 0, "R2", "no output before alignment", nv, 0);
    baud_in = 1; ser_in = 1;
    @(negedge clk);
    baud_in = 0;
    chk(frame_err == 0, "R10", "no error on first edge", frame_err, 0);

    for (int j = 0; j < NV; j++) send_frame(VEC[j], 1'b1, PW[j]);

    send_frame(48'h0F0F_3C_F0F0_C3, 1'b0, 1); // R8 free-running wrap follows
    send_frame(48'h7777_11_8888_22, 1'b1, 1); // R8 frame without a start edge

    send_partial(48'hCAFE_44_BEEF_55, 30, 1); // R9 edge mid word B
    send_frame(48'h1357_9B_2468_AC, 1'b1, 1); // R3 capture restarts at bit 0
    send_partial(48'h3333_66_9999_CC, 23, 0); // R9 edge where word A would complete
    send_frame(48'h4242_18_8181_E7, 1'b1, 1);

    for (int i = 0; i < 10; i++) begin ser_in = 1; baud_in = 0; @(negedge clk); end
    rst_n = 0;
    @(negedge clk);
    chk(smp_word == 0 && ctrl_a == 0 && ctrl_b == 0 && !smp_valid, "R1",
        "reset mid-frame", {smp_word, ctrl_a, ctrl_b}, 0);
    rst_n = 1;
    nv = 0;
    for (int i = 0; i < 50; i++) begin
      ser_in = i[1];
      @(negedge clk);
      nv += int'(smp_valid) + int'(frame_err);
    end
    chk(nv == 0, "R2", "no output before realignment", nv, 0);
    baud_in = 1;
    @(negedge clk);
    chk(frame_err == 0, "R10", "no error on realigning edge", frame_err, 0);
    hi_left = 2; // R7 strobe stays high into the frame
    send_frame(48'h5555_AA_AAAA_55, 1'b1, 1);
    baud_in = 0;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule